// File: doc/BRIEF.md
# PLL Lock Clock-Switch Sequencer

This block watches the lock-detect signal of a clock-recovery PLL and decides when the master clock of a receiver moves between a free-running reference clock and the recovered PLL clock. The block runs entirely on the reference clock. It counts every interval in reference-clock cycles, or in word ticks that it divides down from that clock. Its select output drives an external glitch-free clock multiplexer.

Each lock change is marked by a transition pulse, and the pulse polarity can be selected. On lock-in, the pulse starts on a word tick. The clock select moves to the PLL a programmable delay later. A receive-error flag clears, and the pulse ends, once a qualification period has elapsed. On loss of lock, the error flag rises, the pulse starts and the select returns to the reference clock, all in the same cycle. The pulse then ends after a fixed number of word ticks. A loss of lock during the lock-in sequence abandons that sequence and starts the unlock sequence at once.

Top module: `clk_switch_seq`

## Requirements
- R1: After reset, and for as long as lock has never been seen, `rx_err` is 1, `sel_pll` is 0 and the pulse is inactive.
- R2: When `pulse_pol` is 0, the pulse output `xsn_pulse` is 0 while the pulse is active and 1 while it is idle. When `pulse_pol` is 1, both levels are inverted.
- R3: `lock_raw` passes through a two-flop synchronizer. Word ticks are one-cycle strobes spaced `WCLK_DIV` cycles apart. A lock-in pulse starts on the first word tick after the synchronized lock is seen, so it becomes visible between 4 and 3+`WCLK_DIV` cycles after `lock_raw` rises.
- R4: During lock-in, `rx_err` falls and the pulse ends in the same cycle, exactly `QUAL_CYC` cycles after the pulse started.
- R5: During lock-in, `sel_pll` rises exactly `DLY_n` cycles after the pulse starts, where n is the value of `dly_code`. Code 0 gives the longest delay and code 3 the shortest. Once `rx_err` is 0, `sel_pll` is 1.
- R6: When `lock_raw` falls while locked, then 3 cycles later `rx_err` rises, the pulse starts and `sel_pll` falls, all in the same cycle.
- R7: The unlock pulse ends on the `UNLOCK_TICKS`-th word tick after it starts. Its length is therefore between (`UNLOCK_TICKS`-1)·`WCLK_DIV`+1 and `UNLOCK_TICKS`·`WCLK_DIV` cycles.
- R8: If lock is lost during lock-in, the pulse stays active and the unlock sequence starts. `rx_err` never falls, and `sel_pll` never rises if its delay had not yet expired.
- R9: A return of lock during the unlock pulse is ignored until the pulse ends. A new lock-in pulse then starts on the next word tick, between 2 and 1+`WCLK_DIV` cycles after the unlock pulse ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_raw | input | 1 | Asynchronous PLL lock-detect input |
| pulse_pol | input | 1 | Transition pulse polarity (0 = active-low) |
| dly_code | input | 2 | Clock-switch delay select, 0 = longest |
| rx_err | output | 1 | Receive-error flag, 1 while not qualified as locked |
| sel_pll | output | 1 | Clock select, 1 = PLL clock, 0 = reference clock |
| xsn_pulse | output | 1 | Transition pulse |

## Verification
The lock-in and unlock sequence is run once for each of the four delay codes, and each run uses an alternate pulse polarity. This separates the delay mapping, the polarity handling and the qualification count from one another. A loss of lock partway through lock-in tells an abandoned sequence apart from a completed one: the error flag must never clear, and the select must never rise. A return of lock during the unlock pulse shows whether the unlock count is honoured before lock-in restarts. A behavioural model is compared on every cycle, and it catches any error in the word-tick phase or in the synchronizer latency.

// File: rtl/clk_switch_pkg.sv
// Shared types for the clock-switch sequencer.
// Assumes nothing beyond standard synthesizable SystemVerilog.
package clk_switch_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_FREE,  // unlocked, reference clock, idle
        ST_ARM,   // lock seen, waiting for a word tick
        ST_QUAL,  // lock-in pulse active, qualifying
        ST_LOCK,  // locked and qualified
        ST_DROP   // unlock pulse active, counting word ticks
    } seq_state_t;

endpackage

// File: rtl/css_sync.sv
// Two-flop synchronizer for the asynchronous lock-detect input.
// Assumes the input is quasi-static relative to the reference clock.
module css_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic meta_q;

    // Shift the input through two flops; reset reads as unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            q_sync <= 1'b0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/css_word_tick.sv
// Divides the reference clock into a registered one-cycle word tick.
// Assumes DIV >= 2; the tick first appears DIV cycles after reset.
module css_word_tick #(
    parameter int DIV = 512
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    // Wrap the counter and register the strobe at its last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + W'(1);
            tick  <= (cnt_q == LAST);
        end
    end
endmodule

// File: rtl/css_delay_sel.sv
// Maps the 2-bit delay code to a clock-switch delay in reference cycles.
// Assumes the table is ordered longest (code 0) to shortest (code 3).
module css_delay_sel #(
    parameter int CW   = 18,
    parameter int DLY0 = 66355,
    parameter int DLY1 = 33178,
    parameter int DLY2 = 16589,
    parameter int DLY3 = 8294
) (
    input  logic [1:0]    code,
    output logic [CW-1:0] dly
);
    // Pick the delay for the current code.
    always_comb begin
        unique case (code)
            2'd0:    dly = CW'(DLY0);
            2'd1:    dly = CW'(DLY1);
            2'd2:    dly = CW'(DLY2);
            default: dly = CW'(DLY3);
        endcase
    end
endmodule

// File: rtl/css_seq_fsm.sv
// Lock-in / unlock sequencer: drives the error flag, the pulse-active
// state and the clock select from the synchronized lock and word tick.
// Assumes dly >= 1; if dly exceeds QUAL_CYC the select moves at lock.
module css_seq_fsm
    import clk_switch_pkg::*;
#(
    parameter int CW           = 18,
    parameter int QUAL_CYC     = 73728,
    parameter int UNLOCK_TICKS = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock_s,
    input  logic          tick,
    input  logic [CW-1:0] dly,
    output logic          err_q,
    output logic          act_q,
    output logic          sel_q
);
    localparam logic [CW-1:0] QUAL_LAST = CW'(QUAL_CYC - 1);
    localparam logic [CW-1:0] TICK_LAST = CW'(UNLOCK_TICKS - 1);

    seq_state_t    state_q;
    logic [CW-1:0] cnt_q;

    // Advance the sequence; lock loss outside the idle phases wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            cnt_q   <= '0;
            err_q   <= 1'b1;
            act_q   <= 1'b0;
            sel_q   <= 1'b0;
        end else if (!lock_s && (state_q == ST_ARM || state_q == ST_QUAL ||
                                 state_q == ST_LOCK)) begin
            state_q <= ST_DROP;
            cnt_q   <= '0;
            err_q   <= 1'b1;
            act_q   <= 1'b1;
            sel_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_FREE: begin
                    if (lock_s) state_q <= ST_ARM;
                end
                ST_ARM: begin
                    if (tick) begin
                        state_q <= ST_QUAL;
                        act_q   <= 1'b1;
                        cnt_q   <= '0;
                    end
                end
                ST_QUAL: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == dly - CW'(1)) sel_q <= 1'b1;
                    if (cnt_q == QUAL_LAST) begin
                        state_q <= ST_LOCK;
                        err_q   <= 1'b0;
                        act_q   <= 1'b0;
                        sel_q   <= 1'b1;
                    end
                end
                ST_DROP: begin
                    if (tick) begin
                        if (cnt_q == TICK_LAST) begin
                            state_q <= ST_FREE;
                            act_q   <= 1'b0;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/clk_switch_seq.sv
// Top of the clock-switch sequencer. Everything runs on the reference
// clock; the select output feeds an external glitch-free clock mux.
// Assumes every duration parameter is >= 1 and WCLK_DIV >= 2.
module clk_switch_seq #(
    parameter int WCLK_DIV     = 512,
    parameter int QUAL_CYC     = 73728,
    parameter int DLY0         = 66355,
    parameter int DLY1         = 33178,
    parameter int DLY2         = 16589,
    parameter int DLY3         = 8294,
    parameter int UNLOCK_TICKS = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lock_raw,
    input  logic       pulse_pol,
    input  logic [1:0] dly_code,
    output logic       rx_err,
    output logic       sel_pll,
    output logic       xsn_pulse
);
    localparam int MAX_A = (QUAL_CYC > DLY0) ? QUAL_CYC : DLY0;
    localparam int MAX_B = (MAX_A > UNLOCK_TICKS) ? MAX_A : UNLOCK_TICKS;
    localparam int CW    = $clog2(MAX_B + 1) + 1;

    logic          lock_s;
    logic          word_tick;
    logic          pulse_act;
    logic [CW-1:0] dly_cyc;

    css_sync sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (lock_raw),
        .q_sync  (lock_s)
    );

    css_word_tick #(.DIV(WCLK_DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (word_tick)
    );

    css_delay_sel #(
        .CW(CW), .DLY0(DLY0), .DLY1(DLY1), .DLY2(DLY2), .DLY3(DLY3)
    ) dsel_i (
        .code (dly_code),
        .dly  (dly_cyc)
    );

    css_seq_fsm #(
        .CW(CW), .QUAL_CYC(QUAL_CYC), .UNLOCK_TICKS(UNLOCK_TICKS)
    ) fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock_s (lock_s),
        .tick   (word_tick),
        .dly    (dly_cyc),
        .err_q  (rx_err),
        .act_q  (pulse_act),
        .sel_q  (sel_pll)
    );

    // Apply the selected polarity to the pulse-active state.
    always_comb xsn_pulse = pulse_pol ? pulse_act : ~pulse_act;

endmodule

// File: rtl/css_checker.sv
// Temporal checks on the sequencer, bound into the top module.
// Assumes the synchronous active-low reset is held for at least one edge.
module css_checker (
    input logic clk,
    input logic rst_n,
    input logic lock_s,
    input logic word_tick,
    input logic pulse_act,
    input logic rx_err,
    input logic sel_pll
);
    // R3: a lock-in pulse only starts after a word tick
    assert_lockin_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pulse_act) && $past(lock_s)) |-> $past(word_tick));

    // R3: the word tick is a single-cycle strobe
    assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_tick |=> !word_tick);

    // R4: error clears together with the end of the lock-in pulse
    assert_err_pulse_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_err) |-> $fell(pulse_act));

    // R5: a qualified lock always selects the PLL clock
    assert_locked_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_err |-> sel_pll);

    // R6: error rise comes with an active pulse and the reference clock
    assert_drop_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_err) |-> (pulse_act && !sel_pll));

    // R6: the select only falls on the unlock entry
    assert_sel_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_pll) |-> (rx_err && pulse_act));

    // R8: without synchronized lock the error flag is set next cycle
    assert_no_lock_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_s |=> rx_err);
endmodule

bind clk_switch_seq css_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_s    (lock_s),
    .word_tick (word_tick),
    .pulse_act (pulse_act),
    .rx_err    (rx_err),
    .sel_pll   (sel_pll)
);

// File: tb/clk_switch_seq_tb.sv
// Bench for the clock-switch sequencer: a behavioural model compared on
// every cycle, plus directed timing checks on the measured edges.
module clk_switch_seq_tb_top;
    localparam int DIV = 4;
    localparam int QUAL = 40;
    localparam int D0 = 20, D1 = 14, D2 = 8, D3 = 4;
    localparam int UT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_raw = 1'b0;
    logic pulse_pol = 1'b0;
    logic [1:0] dly_code = 2'd0;
    logic rx_err, sel_pll, xsn_pulse;

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    clk_switch_seq #(
        .WCLK_DIV(DIV), .QUAL_CYC(QUAL), .DLY0(D0), .DLY1(D1),
        .DLY2(D2), .DLY3(D3), .UNLOCK_TICKS(UT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .lock_raw(lock_raw), .pulse_pol(pulse_pol),
        .dly_code(dly_code), .rx_err(rx_err), .sel_pll(sel_pll),
        .xsn_pulse(xsn_pulse)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int dly_of(input logic [1:0] c);
        return (c == 2'd0) ? D0 : (c == 2'd1) ? D1 : (c == 2'd2) ? D2 : D3;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural model: 0 idle, 1 armed, 2 qualifying, 3 locked, 4 dropping
    int m_mode, m_cnt, m_div;
    bit m_err, m_act, m_sel, m_tick;
    bit sq[$];

    always @(posedge clk) begin
        bit ls, tk;
        int dl;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_div = 0; m_tick = 0;
            m_err = 1; m_act = 0; m_sel = 0;
            sq = '{1'b0, 1'b0};
        end else begin
            ls = sq[1];
            tk = m_tick;
            dl = dly_of(dly_code);
            if (!ls && (m_mode == 1 || m_mode == 2 || m_mode == 3)) begin
                m_mode = 4; m_cnt = 0; m_err = 1; m_act = 1; m_sel = 0;
            end else if (m_mode == 0) begin
                if (ls) m_mode = 1;
            end else if (m_mode == 1) begin
                if (tk) begin m_mode = 2; m_act = 1; m_cnt = 0; end
            end else if (m_mode == 2) begin
                if (m_cnt == dl - 1) m_sel = 1;
                if (m_cnt == QUAL - 1) begin
                    m_mode = 3; m_err = 0; m_act = 0; m_sel = 1;
                end
                m_cnt++;
            end else if (m_mode == 4 && tk) begin
                m_cnt++;
                if (m_cnt == UT) begin m_mode = 0; m_act = 0; m_cnt = 0; end
            end
            sq.push_front(lock_raw);
            void'(sq.pop_back());
            m_tick = (m_div == DIV - 1);
            m_div = (m_div + 1) % DIV;
        end
    end

    // Per-cycle comparison and edge monitor
    bit p_act, p_sel, p_err;
    int t_ar, t_af, t_sr, t_sf, t_ef, t_er, n_ef, n_sr;
    bit act_obs;

    always @(negedge clk) begin
        act_obs = pulse_pol ? xsn_pulse : !xsn_pulse;
        if (rst_n) begin
            chk(rx_err === m_err, "R4/R6/R8", "model rx_err", rx_err, m_err);
            chk(sel_pll === m_sel, "R5/R6", "model sel_pll", sel_pll, m_sel);
            chk(xsn_pulse === (pulse_pol ? m_act : !m_act), "R2/R3/R7/R9",
                "model xsn_pulse", xsn_pulse, pulse_pol ? m_act : !m_act);
            if (act_obs && !p_act) t_ar = cyc;
            if (!act_obs && p_act) t_af = cyc;
            if (sel_pll && !p_sel) begin t_sr = cyc; n_sr++; end
            if (!sel_pll && p_sel) t_sf = cyc;
            if (!rx_err && p_err) begin t_ef = cyc; n_ef++; end
            if (rx_err && !p_err) t_er = cyc;
        end
        p_act = act_obs; p_sel = sel_pll; p_err = rx_err;
    end

    function automatic bit act_now();
        return pulse_pol ? xsn_pulse : !xsn_pulse;
    endfunction

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
    endtask

    task automatic wait_err(input bit v, input string req);
        int k = 0;
        while (rx_err !== v && k < 500) begin step(1); k++; end
        chk(rx_err === v, req, "rx_err reached", rx_err, v);
    endtask

    task automatic wait_act(input bit v, input string req);
        int k = 0;
        while (act_now() !== v && k < 500) begin step(1); k++; end
        chk(act_now() === v, req, "pulse state reached", act_now(), v);
    endtask

    task automatic lock_in(input logic [1:0] code, input bit pol);
        int t0;
        dly_code = code; pulse_pol = pol; lock_raw = 1'b1; t0 = cyc;
        wait_err(1'b0, "R4");
        step(1);
        chk(t_ar >= t0 + 4 && t_ar <= t0 + 3 + DIV, "R3", "pulse start delay",
            t_ar - t0, 4);
        chk(t_ef - t_ar == QUAL, "R4", "qualification length", t_ef - t_ar, QUAL);
        chk(t_af == t_ef, "R4", "pulse end vs error fall", t_af, t_ef);
        chk(t_sr - t_ar == dly_of(code), "R5", "switch delay", t_sr - t_ar,
            dly_of(code));
        chk(xsn_pulse === !pol, "R2", "idle pulse level", xsn_pulse, !pol);
    endtask

    task automatic unlock();
        int t0;
        lock_raw = 1'b0; t0 = cyc;
        wait_err(1'b1, "R6");
        chk(t_er == t0 + 3, "R6", "error rise latency", t_er - t0, 3);
        chk(t_sf == t0 + 3, "R6", "select fall latency", t_sf - t0, 3);
        chk(t_ar == t0 + 3, "R6", "unlock pulse start", t_ar - t0, 3);
        chk(xsn_pulse === pulse_pol, "R2", "active pulse level", xsn_pulse,
            pulse_pol);
        wait_act(1'b0, "R7");
        chk(t_af - t_er >= (UT - 1) * DIV + 1 && t_af - t_er <= UT * DIV, "R7",
            "unlock pulse length", t_af - t_er, UT * DIV);
    endtask

    initial begin
        int ne, ns;
        step(4);
        rst_n = 1'b1;
        step(1);
        chk(rx_err === 1'b1, "R1", "reset rx_err", rx_err, 1);
        chk(sel_pll === 1'b0, "R1", "reset sel_pll", sel_pll, 0);
        chk(xsn_pulse === 1'b1, "R1", "reset pulse idle", xsn_pulse, 1);
        step(12);
        chk(rx_err === 1'b1 && sel_pll === 1'b0, "R1", "unlocked hold",
            sel_pll, 0);

        lock_in(2'd0, 1'b0); step(7); unlock(); step(3);
        lock_in(2'd3, 1'b1); step(5); unlock(); step(2);
        lock_in(2'd1, 1'b0); step(9); unlock(); step(6);
        lock_in(2'd2, 1'b1); step(4); unlock(); step(3);

        // R8: abandon lock-in before the switch delay expires
        pulse_pol = 1'b0; dly_code = 2'd0; lock_raw = 1'b1;
        wait_act(1'b1, "R8");
        step(5);
        ne = n_ef; ns = n_sr;
        lock_raw = 1'b0;
        step(4);
        chk(act_now() === 1'b1, "R8", "pulse held on abandon", act_now(), 1);
        chk(rx_err === 1'b1 && sel_pll === 1'b0, "R8", "select on abandon",
            sel_pll, 0);
        wait_act(1'b0, "R8");
        chk(n_ef == ne, "R8", "error falls during abandon", n_ef - ne, 0);
        chk(n_sr == ns, "R8", "select rises during abandon", n_sr - ns, 0);
        step(3);

        // R9: lock returns while the unlock pulse is counting
        lock_in(2'd3, 1'b0); step(3);
        lock_raw = 1'b0;
        wait_err(1'b1, "R9");
        step(6);
        lock_raw = 1'b1;
        wait_act(1'b0, "R9");
        chk(rx_err === 1'b1, "R9", "error held at unlock end", rx_err, 1);
        wait_act(1'b1, "R9");
        chk(t_ar - t_af >= 2 && t_ar - t_af <= 1 + DIV, "R9",
            "relock pulse start", t_ar - t_af, 2);
        wait_err(1'b0, "R9");
        step(2);
        chk(sel_pll === 1'b1, "R5", "select after relock", sel_pll, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule